// File: doc/BRIEF.md
# Frequency Synthesizer Loop Core

This block holds the digital part of a phase-locked frequency synthesizer. A reference counter divides the reference clock down to the comparison rate. A programmable counter divides the prescaled oscillator by a 15-bit ratio. A phase-frequency detector compares the two and drives the charge pump's raise and lower controls. The synthesized frequency is the ratio times 16 times the comparison frequency, because a fixed divide-by-16 prescaler sits outside the block. With a 4 MHz reference and the default reference ratio of 512, the comparison rate is 7.8125 kHz.

Five register bits shape the loop. One picks the high or low pump current. One silences the pump. One turns off the tuning-voltage driver. One routes the comparison and divided pulses onto output ports 6 and 7 so they can be probed. A lock flag reports whether the loop has been settled for a run of comparison periods. The whole block runs on the reference clock. Each prescaled oscillator cycle arrives as a single-cycle strobe already brought into that domain.

Top module: `synth_loop_core`

## Requirements
- R1: A comparison event occurs once every REF_DIV reference cycles; the first one follows the REF_DIV-th rising edge after reset is released.
- R2: The programmable divider emits one divided event per N oscillator strobes, where N is the ratio input. It reloads N only at terminal count, so a new ratio applies from the following division period.
- R3: A ratio of zero divides by 32768 (2 to the power RATIO_W).
- R4: A comparison event sets the raise output and a divided event sets the lower output. When both are set, both clear, so raise and lower are never active together.
- R5: While `pump_off` is 1, `pump_up` and `pump_dn` are both 0.
- R6: `pump_hi` follows `cur_hi_sel` (1 selects the high current). `drive_en` is 0 while `drv_off` is 1 and 1 otherwise.
- R7: `lock` rises only on a comparison event, after LOCK_CYCLES consecutive comparison periods in which no detector pulse lasted LOCK_WIN cycles.
- R8: Any detector pulse that stays active for LOCK_WIN consecutive cycles clears `lock` on that cycle and restarts the good-period count.
- R9: With `test_route` at 1, `port_o[6]` carries the comparison pulse and `port_o[7]` carries the divided pulse, each one cycle wide and delayed by one cycle. `port_o[5:0]` always equals `port_in[5:0]`. With `test_route` at 0, `port_o` equals `port_in`.
- R10: After reset, the pump outputs and `lock` are 0 and both dividers start from zero, so the first oscillator strobe produces a divided event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| vco_pulse | input | 1 | One strobe per prescaled oscillator cycle |
| ratio | input | RATIO_W | Programmable division ratio |
| cur_hi_sel | input | 1 | Pump current select bit |
| pump_off | input | 1 | Pump disable bit |
| test_route | input | 1 | Route detector inputs onto ports 6 and 7 |
| drv_off | input | 1 | Tuning driver off bit |
| port_in | input | 8 | Programmed port states |
| pump_up | output | 1 | Charge pump raise |
| pump_dn | output | 1 | Charge pump lower |
| pump_hi | output | 1 | High pump current selected |
| drive_en | output | 1 | Tuning driver enable |
| lock | output | 1 | Loop locked flag |
| port_o | output | 8 | Port states after test override |

## Verification
The assertions check the detector, pump and lock properties on every cycle. Raise and lower are never both active. A comparison event never leaves lower active. A silenced pump stays quiet. A detector pulse that lasts LOCK_WIN cycles always leaves `lock` low. The lock flag only rises together with a comparison event.

Only the bench's scenarios can show the actual division periods. These include the ratio-zero maximum and a ratio change taking effect at the next reload. The scenarios also show that lock is reached for aligned and slightly skewed oscillator phases and is lost for a large skew, that the port override follows the test bit, and what state the block holds after reset.

// File: rtl/synth_loop_core.sv
module synth_loop_core #(
  parameter int RATIO_W     = 15,
  parameter int REF_DIV     = 512,
  parameter int LOCK_WIN    = 8,
  parameter int LOCK_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vco_pulse,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               cur_hi_sel,
  input  logic               pump_off,
  input  logic               test_route,
  input  logic               drv_off,
  input  logic [7:0]         port_in,
  output logic               pump_up,
  output logic               pump_dn,
  output logic               pump_hi,
  output logic               drive_en,
  output logic               lock,
  output logic [7:0]         port_o
);
  localparam int RW = $clog2(REF_DIV);
  localparam int DW = RATIO_W + 1;
  localparam int WW = $clog2(LOCK_WIN + 1);
  localparam int GW = $clog2(LOCK_CYCLES);

  logic [RW-1:0] ref_cnt;
  logic [DW-1:0] div_cnt;
  logic [DW-1:0] div_load;
  logic [WW-1:0] wid;
  logic [GW-1:0] good;
  logic up_q, dn_q, comp_q, div_q, bad_q, lock_q;
  logic comp_ev, div_ev, active, wide, up_n, dn_n;

  assign comp_ev  = ref_cnt == RW'(REF_DIV - 1);
  assign div_ev   = vco_pulse && (div_cnt <= DW'(1));
  assign div_load = (ratio == '0) ? (DW'(1) << RATIO_W) : {1'b0, ratio};
  assign active   = up_q | dn_q;
  assign wide     = active && (wid >= WW'(LOCK_WIN - 1));
  assign up_n     = up_q | comp_ev;
  assign dn_n     = dn_q | div_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_cnt <= '0;
      div_cnt <= '0;
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      comp_q  <= 1'b0;
      div_q   <= 1'b0;
    end else begin
      ref_cnt <= comp_ev ? '0 : ref_cnt + 1'b1;
      if (vco_pulse) div_cnt <= div_ev ? div_load : div_cnt - 1'b1;
      up_q   <= up_n & ~dn_n;
      dn_q   <= dn_n & ~up_n;
      comp_q <= comp_ev;
      div_q  <= div_ev;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wid    <= '0;
      good   <= '0;
      bad_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (!active) wid <= '0;
      else if (wid != WW'(LOCK_WIN)) wid <= wid + 1'b1;
      bad_q <= comp_ev ? 1'b0 : (bad_q | wide);
      if (wide) begin
        good   <= '0;
        lock_q <= 1'b0;
      end else if (comp_ev && !bad_q) begin
        if (good == GW'(LOCK_CYCLES - 1)) lock_q <= 1'b1;
        else good <= good + 1'b1;
      end
    end
  end

  assign pump_up  = up_q & ~pump_off;
  assign pump_dn  = dn_q & ~pump_off;
  assign pump_hi  = cur_hi_sel;
  assign drive_en = ~drv_off;
  assign lock     = lock_q;
  assign port_o   = test_route ? {div_q, comp_q, port_in[5:0]} : port_in;
endmodule

// File: rtl/synth_loop_core_chk.sv
module synth_loop_core_chk #(
  parameter int LOCK_WIN = 8
) (
  input logic clk,
  input logic rst,
  input logic up_q,
  input logic dn_q,
  input logic comp_q,
  input logic lock_q,
  input logic pump_off,
  input logic pump_up,
  input logic pump_dn
);
  localparam int CW = $clog2(LOCK_WIN + 1) + 1;
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (!(up_q | dn_q)) run <= '0;
    else if (run < CW'(LOCK_WIN)) run <= run + 1'b1;
  end

  p_exclusive_r4: assert property (@(posedge clk) disable iff (rst) !(up_q && dn_q));
  p_comp_clears_dn_r4: assert property (@(posedge clk) disable iff (rst) comp_q |-> !dn_q);
  p_pump_quiet_r5: assert property (@(posedge clk) disable iff (rst) pump_off |-> (!pump_up && !pump_dn));
  p_lock_at_comp_r7: assert property (@(posedge clk) disable iff (rst) $rose(lock_q) |-> comp_q);
  p_wide_unlock_r8: assert property (@(posedge clk) disable iff (rst) (run >= CW'(LOCK_WIN)) |-> !lock_q);
endmodule

bind synth_loop_core synth_loop_core_chk #(.LOCK_WIN(LOCK_WIN)) i_chk (
  .clk(clk), .rst(rst), .up_q(up_q), .dn_q(dn_q), .comp_q(comp_q),
  .lock_q(lock_q), .pump_off(pump_off), .pump_up(pump_up), .pump_dn(pump_dn)
);

// File: tb/test_synth_loop_core.sv
module test_synth_loop_core;
  localparam int CLK_PERIOD = 10;
  localparam int RD  = 16;
  localparam int WIN = 4;
  localparam int LC  = 16;

  logic clk = 0, rst = 1, vco = 0;
  logic [14:0] ratio = 15'd1;
  logic cp = 0, t0 = 0, t1 = 0, os = 0;
  logic [7:0] pin = 8'h00;
  logic pump_up, pump_dn, pump_hi, drive_en, lock;
  logic [7:0] port_o;

  int errors = 0, checks = 0, cycles = 0;
  int vmode = 0, vph = 0;
  bit started = 0, done = 0;

  int m_ref = 0, m_div = 0, m_wid = 0, m_good = 0;
  bit m_up = 0, m_dn = 0, m_bad = 0, m_lock = 0, m_cq = 0, m_dq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_loop_core #(.REF_DIV(RD), .LOCK_WIN(WIN), .LOCK_CYCLES(LC)) i_synth_loop_core (
    .clk(clk), .rst(rst), .vco_pulse(vco), .ratio(ratio), .cur_hi_sel(cp),
    .pump_off(t0), .test_route(t1), .drv_off(os), .port_in(pin),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_hi(pump_hi), .drive_en(drive_en),
    .lock(lock), .port_o(port_o));

  always @(posedge clk) begin
    bit c, d, wide, act, u, dd;
    int n;
    started = 1;
    cycles++;
    if (rst) begin
      m_ref = 0; m_div = 0; m_wid = 0; m_good = 0;
      m_up = 0; m_dn = 0; m_bad = 0; m_lock = 0; m_cq = 0; m_dq = 0;
    end else begin
      c = (m_ref == RD - 1);
      d = vco && (m_div <= 1);
      n = (ratio == 0) ? 32768 : int'(ratio);
      act = m_up || m_dn;
      wide = act && (m_wid >= WIN - 1);
      if (wide) begin m_good = 0; m_lock = 0; end
      else if (c && !m_bad) begin
        if (m_good == LC - 1) m_lock = 1; else m_good++;
      end
      m_bad = c ? 0 : (m_bad || wide);
      m_wid = !act ? 0 : (m_wid == WIN ? m_wid : m_wid + 1);
      m_ref = c ? 0 : m_ref + 1;
      if (vco) m_div = (m_div <= 1) ? n : m_div - 1;
      u = m_up || c; dd = m_dn || d;
      if (u && dd) begin u = 0; dd = 0; end
      m_up = u; m_dn = dd;
      m_cq = c; m_dq = d;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R4 pump_up", pump_up, m_up && !t0);
      chk(t0 ? "R5 pump_dn" : "R4 pump_dn", pump_dn, m_dn && !t0);
      chk("R6 pump_hi", pump_hi, cp);
      chk("R6 drive_en", drive_en, !os);
      chk("R7/R8 lock", lock, m_lock);
      chk("R9 port_o", port_o, t1 ? {m_dq, m_cq, pin[5:0]} : pin);
    end
    case (vmode)
      1: vco = 1;
      2: vco = (m_ref == vph);
      default: vco = 0;
    endcase
  end

  task automatic gap(input int b, output int g);
    while (!port_o[b]) @(negedge clk);
    @(negedge clk);
    g = 1;
    while (!port_o[b]) begin @(negedge clk); g++; end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 200000 && !done) begin
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
    finish_run();
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    chk("R10 reset pump_up", pump_up, 0);
    chk("R10 reset pump_dn", pump_dn, 0);
    chk("R10 reset lock", lock, 0);
    rst = 0;
    vmode = 2; vph = RD - 1;
    repeat (20 * RD) @(negedge clk);
    chk("R7 aligned lock", lock, 1);
    vph = RD - 9;
    repeat (3 * RD) @(negedge clk);
    chk("R8 skew unlock", lock, 0);
    vph = RD - 3;
    repeat (20 * RD) @(negedge clk);
    chk("R7 small skew lock", lock, 1);
    t0 = 1; cp = 1; os = 1;
    repeat (2 * RD) @(negedge clk);
    chk("R5 pump_up off", pump_up, 0);
    chk("R5 pump_dn off", pump_dn, 0);
    chk("R6 hi current", pump_hi, 1);
    chk("R6 driver off", drive_en, 0);
    t0 = 0; cp = 0; os = 0;
    t1 = 1; pin = 8'hA5; vmode = 1; ratio = 15'd3;
    gap(6, g); chk("R1 comparison period", g, RD);
    gap(7, g); gap(7, g); chk("R2 ratio 3 period", g, 3);
    chk("R9 low ports pass", port_o[5:0], 6'h25);
    ratio = 15'd5;
    gap(7, g); gap(7, g); chk("R2 ratio 5 after reload", g, 5);
    ratio = 15'd0;
    gap(7, g); gap(7, g); chk("R3 ratio zero period", g, 32768);
    t1 = 0; pin = 8'h3C;
    @(negedge clk);
    chk("R9 ports pass", port_o, 8'h3C);
    finish_run();
  end
endmodule